// File: doc/BRIEF.md
# Packed SIMD Lane Compare Unit

This unit compares two 64-bit packed operands lane by lane and returns a lane mask that is meant to overwrite the destination operand. Six operations are recognised: equality and signed greater-than, each at 8-, 16- or 32-bit lane width. For each lane, the result is all ones when the test holds and all zeros when it fails. The operation is chosen by the opcode byte that follows the two-byte-opcode escape.

The caller presents the destination operand (`dst_i`), the source operand (`src_i`), the opcode byte and a valid strobe in the same cycle. It does not matter whether the source came from a register or from memory: the unit only sees a 64-bit value. The result is registered. It appears together with `res_valid_o` on the next clock, and a new operation can be accepted every cycle.

When the opcode is not one of the six, no result is written. `res_o` keeps its last value, and `illegal_o` pulses for one cycle.

Top module: `simd_lane_cmp_unit`

## Requirements
- R1: While `rst_n` is low, `res_valid_o`, `illegal_o` and `res_o` are all zero.
- R2: Opcode 0x74 tests each of the eight byte lanes for equality. A lane where dst equals src gives 0xFF and any other lane gives 0x00.
- R3: Opcode 0x75 applies the same equality test to four 16-bit lanes, giving 0xFFFF or 0x0000 per lane.
- R4: Opcode 0x76 applies the same equality test to two 32-bit lanes, giving 0xFFFFFFFF or 0x00000000 per lane.
- R5: Opcode 0x64 sets a byte lane to 0xFF when the dst lane is greater than the src lane as two's-complement signed values, and to 0x00 otherwise. For example, 0x80 is not greater than 0x7F.
- R6: Opcode 0x65 applies the signed greater-than test to 16-bit lanes.
- R7: Opcode 0x66 applies the signed greater-than test to 32-bit lanes.
- R8: A legal operation accepted on a clock edge gives `res_valid_o` high with its result on `res_o` after that edge, one clock of latency. Back-to-back operations each produce a result on consecutive cycles.
- R9: A valid operation with any other opcode gives `illegal_o` high and `res_valid_o` low for exactly one cycle, and leaves `res_o` unchanged.
- R10: A cycle with `op_valid_i` low gives `res_valid_o` and `illegal_o` low on the next cycle and leaves `res_o` unchanged.
- R11: Whenever `res_valid_o` is high, every byte of `res_o` is either 0x00 or 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Operation present this cycle |
| op_code_i | input | 8 | Opcode byte following the escape |
| dst_i | input | 64 | First operand, replaced by the result |
| src_i | input | 64 | Second operand, from a register or from memory |
| res_valid_o | output | 1 | Result valid, one cycle after acceptance |
| res_o | output | 64 | Registered lane mask |
| illegal_o | output | 1 | One-cycle pulse for an unsupported opcode |

## Verification
The bench goes after the signed boundary lanes 0x80 against 0x7F, and the same boundary at 16 and 32 bits. A design that compared unsigned would invert those masks. It also forces lanes where the two operands are equal: a greater-than test that leaked `>=` would set those lanes, and an equality test sized to the wrong lane width would smear the mask across neighbouring bytes. Opcodes next to the legal ones (0x67, 0x77) check that a decoder which ignores the low bits, or treats width code 3 as valid, still gets flagged as illegal and leaves the previous result untouched. Idle gaps mixed into back-to-back traffic catch a valid strobe that lingers, and a result that is overwritten when no operation was accepted.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;

    typedef enum logic [1:0] {
        LW_BYTE  = 2'd0,
        LW_WORD  = 2'd1,
        LW_DWORD = 2'd2
    } lane_w_e;

    typedef enum logic {
        CK_EQ = 1'b0,
        CK_GT = 1'b1
    } cmp_kind_e;

    typedef struct packed {
        logic      legal;
        cmp_kind_e kind;
        lane_w_e   width;
    } cmp_op_t;

endpackage

// File: rtl/simd_cmp_decode.sv
module simd_cmp_decode
    import simd_cmp_pkg::*;
#(
    parameter logic [7:0] EQ_BASE = 8'h74,
    parameter logic [7:0] GT_BASE = 8'h64
) (
    input  logic [7:0] opcode,
    output cmp_op_t    op
);
    localparam logic [7:0] N_WIDTHS = 8'd3;

    logic [7:0] eq_off;
    logic [7:0] gt_off;

    always_comb begin
        eq_off   = opcode - EQ_BASE;
        gt_off   = opcode - GT_BASE;
        op.legal = 1'b0;
        op.kind  = CK_EQ;
        op.width = LW_BYTE;
        if (eq_off < N_WIDTHS) begin
            op.legal = 1'b1;
            op.kind  = CK_EQ;
            op.width = lane_w_e'(eq_off[1:0]);
        end else if (gt_off < N_WIDTHS) begin
            op.legal = 1'b1;
            op.kind  = CK_GT;
            op.width = lane_w_e'(gt_off[1:0]);
        end
    end
endmodule

// File: rtl/simd_cmp_lane_slice.sv
module simd_cmp_lane_slice
    import simd_cmp_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  cmp_kind_e    kind,
    output logic [W-1:0] mask
);
    logic eq_hit;
    logic gt_hit;
    logic hit;

    always_comb begin
        eq_hit = (a == b);
        gt_hit = ($signed(a) > $signed(b));
        hit    = (kind == CK_GT) ? gt_hit : eq_hit;
        mask   = {W{hit}};
    end
endmodule

// File: rtl/simd_cmp_lanes.sv
module simd_cmp_lanes
    import simd_cmp_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  cmp_op_t           op,
    output logic [DATA_W-1:0] mask
);
    localparam int unsigned N8  = DATA_W / 8;
    localparam int unsigned N16 = DATA_W / 16;
    localparam int unsigned N32 = DATA_W / 32;

    logic [DATA_W-1:0] m8;
    logic [DATA_W-1:0] m16;
    logic [DATA_W-1:0] m32;

    for (genvar i = 0; i < N8; i++) begin : g_b
        simd_cmp_lane_slice #(.W(8)) u_s (
            .a(a[i*8 +: 8]), .b(b[i*8 +: 8]), .kind(op.kind), .mask(m8[i*8 +: 8])
        );
    end
    for (genvar i = 0; i < N16; i++) begin : g_w
        simd_cmp_lane_slice #(.W(16)) u_s (
            .a(a[i*16 +: 16]), .b(b[i*16 +: 16]), .kind(op.kind), .mask(m16[i*16 +: 16])
        );
    end
    for (genvar i = 0; i < N32; i++) begin : g_d
        simd_cmp_lane_slice #(.W(32)) u_s (
            .a(a[i*32 +: 32]), .b(b[i*32 +: 32]), .kind(op.kind), .mask(m32[i*32 +: 32])
        );
    end

    always_comb begin
        unique case (op.width)
            LW_BYTE:  mask = m8;
            LW_WORD:  mask = m16;
            LW_DWORD: mask = m32;
            default:  mask = '0;
        endcase
    end
endmodule

// File: rtl/simd_lane_cmp_unit.sv
module simd_lane_cmp_unit
    import simd_cmp_pkg::*;
#(
    parameter int unsigned DATA_W  = 64,
    parameter logic [7:0]  EQ_BASE = 8'h74,
    parameter logic [7:0]  GT_BASE = 8'h64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid_i,
    input  logic [7:0]        op_code_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    output logic              res_valid_o,
    output logic [DATA_W-1:0] res_o,
    output logic              illegal_o
);
    localparam int unsigned NBYTES = DATA_W / 8;

    typedef struct packed {
        logic              valid;
        logic              ill;
        logic [DATA_W-1:0] res;
    } state_t;

    state_t            st_d;
    state_t            st_q;
    cmp_op_t           dec_op;
    logic [DATA_W-1:0] lane_mask;

    simd_cmp_decode #(.EQ_BASE(EQ_BASE), .GT_BASE(GT_BASE)) u_dec (
        .opcode(op_code_i),
        .op    (dec_op)
    );

    simd_cmp_lanes #(.DATA_W(DATA_W)) u_lanes (
        .a   (dst_i),
        .b   (src_i),
        .op  (dec_op),
        .mask(lane_mask)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.ill   = 1'b0;
        if (op_valid_i) begin
            if (dec_op.legal) begin
                st_d.valid = 1'b1;
                st_d.res   = lane_mask;
            end else begin
                st_d.ill   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid_o = st_q.valid;
    assign illegal_o   = st_q.ill;
    assign res_o       = st_q.res;

    // R8
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && dec_op.legal) |=> (res_valid_o && !illegal_o));

    // R9
    illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && !dec_op.legal) |=> (illegal_o && !res_valid_o));

    // R9
    illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && !dec_op.legal) |=> $stable(res_o));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> (!res_valid_o && !illegal_o && $stable(res_o)));

    // R11
    for (genvar i = 0; i < NBYTES; i++) begin : g_mchk
        byte_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid_o |-> (res_o[i*8 +: 8] == 8'h00 || res_o[i*8 +: 8] == 8'hFF));
    end
endmodule

// File: tb/tb_simd_lane_cmp_unit.sv
`timescale 1ns/1ps
module tb_simd_lane_cmp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid_i = 1'b0;
    logic [7:0]  op_code_i = 8'h00;
    logic [63:0] dst_i = '0;
    logic [63:0] src_i = '0;
    logic        res_valid_o;
    logic [63:0] res_o;
    logic        illegal_o;

    int unsigned nvec = 0;
    int unsigned nfail = 0;
    bit          done = 1'b0;

    logic        exp_v = 1'b0;
    logic        exp_ill = 1'b0;
    logic [63:0] exp_res = '0;
    string       exp_tag = "R10";

    always #2.5 clk = ~clk;

    simd_lane_cmp_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_code_i(op_code_i),
        .dst_i(dst_i), .src_i(src_i), .res_valid_o(res_valid_o), .res_o(res_o),
        .illegal_o(illegal_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // lane reference: sign bit flipped, then unsigned compare
    function automatic void ref_model(input logic [7:0] op, input logic [63:0] a,
                                      input logic [63:0] b, output bit legal,
                                      output logic [63:0] r, output string tag);
        int  wbits = 8;
        bit  gt = 1'b0;
        legal = 1'b1;
        r = '0;
        case (op)
            8'h74: begin wbits = 8;  gt = 0; tag = "R2"; end
            8'h75: begin wbits = 16; gt = 0; tag = "R3"; end
            8'h76: begin wbits = 32; gt = 0; tag = "R4"; end
            8'h64: begin wbits = 8;  gt = 1; tag = "R5"; end
            8'h65: begin wbits = 16; gt = 1; tag = "R6"; end
            8'h66: begin wbits = 32; gt = 1; tag = "R7"; end
            default: begin legal = 1'b0; tag = "R9"; end
        endcase
        if (legal) begin
            logic [63:0] lm = (64'h1 << wbits) - 64'h1;
            logic [63:0] sb = 64'h1 << (wbits - 1);
            for (int l = 0; l < 64 / wbits; l++) begin
                logic [63:0] x = (a >> (l * wbits)) & lm;
                logic [63:0] y = (b >> (l * wbits)) & lm;
                bit hit = gt ? ((x ^ sb) > (y ^ sb)) : (x == y);
                if (hit) r = r | (lm << (l * wbits));
            end
        end
    endfunction

    task automatic check_outputs();
        nvec++;
        chk(res_valid_o === exp_v, exp_v ? "R8" : exp_tag, 64'(res_valid_o), 64'(exp_v));
        chk(illegal_o === exp_ill, exp_ill ? "R9" : exp_tag, 64'(illegal_o), 64'(exp_ill));
        chk(res_o === exp_res, exp_tag, res_o, exp_res);
        if (res_valid_o) begin
            for (int i = 0; i < 8; i++) begin
                logic [7:0] bv = res_o[i*8 +: 8];
                chk(bv == 8'h00 || bv == 8'hFF, "R11", 64'(bv), 64'hFF);
            end
        end
    endtask

    task automatic step(input logic vi, input logic [7:0] oi, input logic [63:0] ai,
                        input logic [63:0] bi);
        bit          legal;
        logic [63:0] r;
        string       tag;
        @(negedge clk);
        check_outputs();
        op_valid_i = vi;
        op_code_i  = oi;
        dst_i      = ai;
        src_i      = bi;
        if (vi) begin
            ref_model(oi, ai, bi, legal, r, tag);
            if (legal) begin
                exp_v = 1'b1; exp_ill = 1'b0; exp_res = r; exp_tag = tag;
            end else begin
                exp_v = 1'b0; exp_ill = 1'b1; exp_tag = "R9";
            end
        end else begin
            exp_v = 1'b0; exp_ill = 1'b0; exp_tag = "R10";
        end
    endtask

    function automatic logic [63:0] rand_opnd(input logic [63:0] other);
        logic [63:0] v;
        for (int i = 0; i < 8; i++) begin
            case ($urandom % 6)
                0: v[i*8 +: 8] = 8'h80;
                1: v[i*8 +: 8] = 8'h7F;
                2: v[i*8 +: 8] = other[i*8 +: 8];
                3: v[i*8 +: 8] = 8'hFF;
                default: v[i*8 +: 8] = 8'($urandom);
            endcase
        end
        return v;
    endfunction

    function automatic logic [7:0] rand_op();
        case ($urandom % 8)
            0: return 8'h74;
            1: return 8'h75;
            2: return 8'h76;
            3: return 8'h64;
            4: return 8'h65;
            5: return 8'h66;
            6: return 8'($urandom);
            default: return 8'h74 + 8'($urandom % 3);
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        nvec++;
        chk(res_valid_o === 1'b0, "R1", 64'(res_valid_o), 64'h0);
        chk(illegal_o === 1'b0, "R1", 64'(illegal_o), 64'h0);
        chk(res_o === 64'h0, "R1", res_o, 64'h0);
        rst_n = 1'b1;

        // directed corners
        step(1, 8'h74, 64'h0011_2233_4455_6677, 64'h0011_2233_4455_6677); // R2 equal
        step(1, 8'h74, 64'h0011_2233_4455_6677, 64'h0011_2299_4455_0077); // R2 mixed
        step(1, 8'h75, 64'h1234_5678_9ABC_DEF0, 64'h1234_5679_9ABC_DEF0); // R3
        step(1, 8'h76, 64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0000); // R4
        step(1, 8'h64, 64'h8080_7F7F_0102_FF00, 64'h7F80_807F_0201_00FF); // R5 sign edges
        step(1, 8'h64, 64'h7F7F_7F7F_7F7F_7F7F, 64'h8080_8080_8080_8080); // R5
        step(1, 8'h65, 64'h8000_7FFF_0001_FFFF, 64'h7FFF_8000_0001_0000); // R6
        step(1, 8'h66, 64'h8000_0000_7FFF_FFFF, 64'h7FFF_FFFF_8000_0000); // R7
        step(1, 8'h66, 64'h1111_1111_1111_1111, 64'h1111_1111_1111_1111); // R7 equal lanes
        step(1, 8'h77, 64'h0, 64'h0);  // R9 width code 3
        step(1, 8'h67, 64'h1, 64'h0);  // R9
        step(0, 8'h74, 64'h5, 64'h5);  // R10 idle
        step(1, 8'h00, 64'h0, 64'h0);  // R9
        step(1, 8'h75, 64'hFFFF_0000_FFFF_0000, 64'hFFFF_0000_0000_FFFF); // R8 back-to-back
        step(1, 8'h65, 64'hFFFF_0000_FFFF_0000, 64'hFFFF_0000_0000_FFFF);

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            logic [63:0] a = rand_opnd(64'($urandom) << 32 | 64'($urandom));
            logic [63:0] b = rand_opnd(a);
            step(($urandom % 10) != 0, rand_op(), a, b);
        end
        step(0, 8'h00, 64'h0, 64'h0);
        step(0, 8'h00, 64'h0, 64'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule